// File: doc/BRIEF.md
# Floating-Point Compare and Status Register Unit

This block holds the floating-point status word of a scalar FPU and updates it one operation at a time. On a start strobe it either loads the whole word, folds externally reported IEEE exception flags into it, or compares two single-precision operands. A compare can be quiet or signalling. Its 2-bit relation code goes into one of four condition-code fields, chosen by a select input.

Every set of exception flags is merged into the current-exception field and then tested against the trap-enable field held in the same word. If an enabled flag is set, the unit records an IEEE-exception trap type and emits a one-cycle trap pulse. The accrued field and the condition field are left untouched in that case. Otherwise the current flags are also ORed into the accrued field. The rounding-direction field is decoded continuously for the arithmetic units downstream.

Top module: `fpStatusUnit`

## Requirements
- R1: After reset `statusReg` is zero, `trapPulse` is low and `roundMode` is 0.
- R2: With `opcode`=3 (load), the cycle after the start strobe `statusReg` equals {`opA`,`opB`}, with `opA` as the upper half, and no trap is raised.
- R3: An operation that raises no exception flag leaves the exception, trap-type and accrued bits unchanged. A flag fold (`opcode`=0) with `flagsIn`=0 leaves the whole register unchanged.
- R4: A flag fold ORs `flagsIn` into the current-exception bits 4:0. The flag order is bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero and bit 0 inexact. When no enabled flag is set, the merged bits are also ORed into the accrued bits 9:5.
- R5: When the merged current-exception bits AND the trap-enable bits 27:23 are non-zero, bits 16:14 become 001 and the accrued bits keep their value. `trapPulse` is high in the cycle after the start strobe.
- R6: A compare writes equal=00, less=01, greater=10 or unordered=11 into the field picked by `fccSel`. The fields are bits 11:10 (0), 33:32 (1), 35:34 (2) and 37:36 (3), and the other three fields keep their value.
- R7: Positive and negative zero compare equal, and negative operands are ordered by value: -2 is less than -1, and -1 is less than +1.
- R8: A quiet compare (`opcode`=1) raises invalid only for a signalling NaN. A signalling NaN has an all-ones exponent, a non-zero fraction and fraction bit 22 clear. A quiet NaN gives unordered with no flag.
- R9: A signalling compare (`opcode`=2) raises invalid whenever either operand is any NaN. For ordered operands it raises no flag.
- R10: A compare whose flags cause a trap leaves every condition-code field unchanged.
- R11: `roundMode` follows bits 31:30: 00 gives 0 (nearest-even), 01 gives 1 (toward zero), 10 gives 2 (toward +infinity) and 11 gives 3 (toward -infinity).
- R12: Without a start strobe `statusReg` holds its value and `trapPulse` stays low.
- R13: `trapPulse` is high only in the cycle that follows a start strobe, and it is low again one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts one operation in this cycle |
| opcode | input | 2 | 0 fold flags, 1 quiet compare, 2 signalling compare, 3 load |
| opA | input | 32 | First compare operand; upper half of load value |
| opB | input | 32 | Second compare operand; lower half of load value |
| fccSel | input | 2 | Condition-code field index for compares |
| flagsIn | input | 5 | Exception flags for a fold operation |
| statusReg | output | 64 | Status register value |
| trapPulse | output | 1 | One-cycle FP exception trap |
| roundMode | output | 2 | Decoded rounding direction |

## Verification
The hardest case is a compare that traps. It needs an enable bit for invalid already loaded, a condition field preset to a known non-zero value, and a NaN operand that raises invalid under the chosen compare variant. The bench first uses a load to place the enable and the preset field together. It then issues a signalling compare against a quiet NaN and checks that the preset field, the accrued bits and the pulse width all come out as required. The quiet-compare distinction between signalling and quiet NaNs is reached with dedicated operand encodings on the upper condition fields.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;
  localparam int FLAG_W = 5;

  typedef enum logic [1:0] {
    OP_FOLD = 2'd0,
    OP_CMPQ = 2'd1,
    OP_CMPS = 2'd2,
    OP_LOAD = 2'd3
  } opKind_e;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'd0,
    RND_ZERO    = 2'd1,
    RND_UP      = 2'd2,
    RND_DOWN    = 2'd3
  } rnd_e;

  typedef struct packed {
    logic              load;
    logic              merge;
    logic              trap;
    logic              accrue;
    logic              writeFcc;
    logic [FLAG_W-1:0] flags;
  } ctrlStrobe_t;
endpackage

// File: rtl/fcmpCore.sv
module fcmpCore #(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         signalling,
  output logic [1:0]   relation,
  output logic         invalid
);
  localparam int FRAC_W = W - 1 - EXP_W;

  logic [1:0]   isNan, isSnan, isZero;
  logic [W-1:0] key [2];

  for (genvar gi = 0; gi < 2; gi++) begin : gOperand
    logic [W-1:0] v;
    assign v = (gi == 0) ? a : b;
    assign isNan[gi]  = (&v[W-2 -: EXP_W]) && (|v[FRAC_W-1:0]);
    assign isSnan[gi] = isNan[gi] && !v[FRAC_W-1];
    assign isZero[gi] = ~|v[W-2:0];
    // map sign-magnitude onto an unsigned ordering
    assign key[gi] = v[W-1] ? ~v : {1'b1, v[W-2:0]};
  end

  always_comb begin
    if (|isNan)                      relation = 2'b11;
    else if (&isZero)                relation = 2'b00;
    else if (key[0] == key[1])       relation = 2'b00;
    else if (key[0] < key[1])        relation = 2'b01;
    else                             relation = 2'b10;
    invalid = signalling ? (|isNan) : (|isSnan);
  end
endmodule

// File: rtl/fsrCtrl.sv
module fsrCtrl
  import fpsu_pkg::*;
(
  input  logic              start,
  input  opKind_e           op,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic              cmpInvalid,
  input  logic [FLAG_W-1:0] cexcQ,
  input  logic [FLAG_W-1:0] temQ,
  output ctrlStrobe_t       strobe
);
  logic              isCmp;
  logic [FLAG_W-1:0] newFlags;
  logic [FLAG_W-1:0] mergedCexc;

  always_comb begin
    isCmp    = (op == OP_CMPQ) || (op == OP_CMPS);
    newFlags = '0;
    if (start) begin
      if (op == OP_FOLD)  newFlags = flagsIn;
      else if (isCmp)     newFlags = {cmpInvalid, {(FLAG_W-1){1'b0}}};
    end
    mergedCexc      = cexcQ | newFlags;
    strobe.flags    = newFlags;
    strobe.load     = start && (op == OP_LOAD);
    strobe.merge    = |newFlags;
    strobe.trap     = strobe.merge && (|(mergedCexc & temQ));
    strobe.accrue   = strobe.merge && !strobe.trap;
    strobe.writeFcc = start && isCmp && !strobe.trap;
  end
endmodule

// File: rtl/fsrDatapath.sv
module fsrDatapath
  import fpsu_pkg::*;
#(
  parameter int REG_W    = 64,
  parameter int CEXC_LSB = 0,
  parameter int FTT_LSB  = 14,
  parameter int TEM_LSB  = 23,
  parameter int RND_LSB  = 30,
  parameter int FCC_BASE = 10,
  parameter int FCC_FAR  = 20,
  parameter int FCC_N    = 4,
  parameter int SEL_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [SEL_W-1:0]  fccSel,
  input  logic [1:0]        relation,
  input  logic [REG_W-1:0]  loadVal,
  output logic [REG_W-1:0]  fsrQ,
  output logic              trapQ,
  output rnd_e              roundMode,
  output logic [FLAG_W-1:0] cexcQ,
  output logic [FLAG_W-1:0] temQ
);
  localparam int AEXC_LSB     = CEXC_LSB + FLAG_W;
  localparam int FTT_W        = 3;
  localparam logic [FTT_W-1:0] FTT_IEEE = 3'b001;

  logic [REG_W-1:0]  fsrNxt;
  logic [FLAG_W-1:0] merged;
  logic [FCC_N-1:0]  fccHit;

  // per-field write enables
  for (genvar gi = 0; gi < FCC_N; gi++) begin : gFccHit
    assign fccHit[gi] = strobe.writeFcc && (fccSel == SEL_W'(gi));
  end

  function automatic int fccLsb(input int idx);
    return FCC_BASE + ((idx == 0) ? 0 : (FCC_FAR + 2 * idx));
  endfunction

  assign cexcQ = fsrQ[CEXC_LSB +: FLAG_W];
  assign temQ  = fsrQ[TEM_LSB  +: FLAG_W];

  always_comb begin
    fsrNxt = fsrQ;
    merged = cexcQ | strobe.flags;
    if (strobe.load) begin
      fsrNxt = loadVal;
    end else begin
      if (strobe.merge) begin
        fsrNxt[CEXC_LSB +: FLAG_W] = merged;
        if (strobe.trap)
          fsrNxt[FTT_LSB +: FTT_W] = FTT_IEEE;
        if (strobe.accrue)
          fsrNxt[AEXC_LSB +: FLAG_W] = fsrQ[AEXC_LSB +: FLAG_W] | merged;
      end
      for (int i = 0; i < FCC_N; i++)
        if (fccHit[i]) fsrNxt[fccLsb(i) +: 2] = relation;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsrQ  <= '0;
      trapQ <= 1'b0;
    end else begin
      fsrQ  <= fsrNxt;
      trapQ <= strobe.trap;
    end
  end

  always_comb begin
    case (fsrQ[RND_LSB +: 2])
      2'b00:   roundMode = RND_NEAREST;
      2'b01:   roundMode = RND_ZERO;
      2'b10:   roundMode = RND_UP;
      2'b11:   roundMode = RND_DOWN;
      default: roundMode = RND_ZERO;
    endcase
  end
endmodule

// File: rtl/fpStatusUnit.sv
module fpStatusUnit
  import fpsu_pkg::*;
#(
  parameter int OPND_W = 32,
  parameter int REG_W  = 64,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        opcode,
  input  logic [OPND_W-1:0] opA,
  input  logic [OPND_W-1:0] opB,
  input  logic [SEL_W-1:0]  fccSel,
  input  logic [4:0]        flagsIn,
  output logic [REG_W-1:0]  statusReg,
  output logic              trapPulse,
  output logic [1:0]        roundMode
);
  opKind_e           opKind;
  ctrlStrobe_t       strobe;
  logic [1:0]        relation;
  logic              cmpInvalid;
  logic [FLAG_W-1:0] cexcQ, temQ;
  rnd_e              rndQ;

  assign opKind = opKind_e'(opcode);

  fcmpCore #(.W(OPND_W), .EXP_W(8)) uCmp (
    .a(opA), .b(opB), .signalling(opKind == OP_CMPS),
    .relation(relation), .invalid(cmpInvalid)
  );

  fsrCtrl uCtrl (
    .start(start), .op(opKind), .flagsIn(flagsIn), .cmpInvalid(cmpInvalid),
    .cexcQ(cexcQ), .temQ(temQ), .strobe(strobe)
  );

  fsrDatapath #(.REG_W(REG_W), .SEL_W(SEL_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fccSel(fccSel),
    .relation(relation), .loadVal({opA, opB}), .fsrQ(statusReg),
    .trapQ(trapPulse), .roundMode(rndQ), .cexcQ(cexcQ), .temQ(temQ)
  );

  assign roundMode = rndQ;
endmodule

// File: rtl/fpStatusUnitChk.sv
module fpStatusUnitChk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [1:0]  opcode,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic [4:0]  flagsIn,
  input logic [63:0] statusReg,
  input logic        trapPulse
);
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ($stable(statusReg) && !trapPulse));

  a_r13_pulse_source: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> $past(start));

  a_r5_trap_type: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> (statusReg[16:14] == 3'b001));

  a_r5_accrued_kept: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> (statusReg[9:5] == $past(statusReg[9:5])));

  a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
    (start && opcode == 2'd3) |=> (statusReg == $past({opA, opB}) && !trapPulse));

  a_r3_zero_fold: assert property (@(posedge clk) disable iff (!rstN)
    (start && opcode == 2'd0 && flagsIn == 5'd0) |=> $stable(statusReg));
endmodule

bind fpStatusUnit fpStatusUnitChk uChk (
  .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .opA(opA),
  .opB(opB), .flagsIn(flagsIn), .statusReg(statusReg), .trapPulse(trapPulse)
);

// File: tb/tb_fpStatusUnit.sv
module tb_fpStatusUnit;
  localparam int CLK_P = 10;
  localparam logic [31:0] ONE = 32'h3F80_0000, TWO = 32'h4000_0000;
  localparam logic [31:0] MONE = 32'hBF80_0000, MTWO = 32'hC000_0000;
  localparam logic [31:0] QNAN = 32'h7FC0_0000, SNAN = 32'h7F80_0001;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [1:0] opcode = '0, fccSel = '0, roundMode;
  logic [31:0] opA = '0, opB = '0;
  logic [4:0] flagsIn = '0;
  logic [63:0] statusReg;
  logic trapPulse;
  int nChecks = 0, nFails = 0;

  always #(CLK_P/2) clk = ~clk;

  fpStatusUnit dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .opA(opA),
    .opB(opB), .fccSel(fccSel), .flagsIn(flagsIn), .statusReg(statusReg),
    .trapPulse(trapPulse), .roundMode(roundMode)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] sel, input logic [4:0] fl);
    @(negedge clk);
    start = 1'b1; opcode = op; opA = a; opB = b; fccSel = sel; flagsIn = fl;
    @(negedge clk);
    start = 1'b0; flagsIn = '0;
  endtask

  task automatic loadReg(input logic [63:0] v);
    runOp(2'd3, v[63:32], v[31:0], 2'd0, 5'd0);
  endtask

  task automatic tReset;
    chk("R1 reg", statusReg, 64'h0);
    chk("R1 trap", {63'h0, trapPulse}, 64'h0);
    chk("R1 round", {62'h0, roundMode}, 64'h0);
  endtask

  task automatic tLoadRound;
    loadReg(64'h1234_5678_4000_0000);
    chk("R2 load value", statusReg, 64'h1234_5678_4000_0000);
    chk("R2 no trap", {63'h0, trapPulse}, 64'h0);
    chk("R11 toward zero", {62'h0, roundMode}, 64'd1);
    loadReg(64'h8000_0000);
    chk("R11 toward +inf", {62'h0, roundMode}, 64'd2);
    loadReg(64'hC000_0000);
    chk("R11 toward -inf", {62'h0, roundMode}, 64'd3);
  endtask

  task automatic tZeroFoldAndIdle;
    loadReg(64'h0000_0001_0000_0003);
    runOp(2'd0, '0, '0, 2'd0, 5'd0);
    chk("R3 zero fold", statusReg, 64'h0000_0001_0000_0003);
    repeat (3) @(negedge clk);
    chk("R12 idle hold", statusReg, 64'h0000_0001_0000_0003);
    chk("R12 idle trap", {63'h0, trapPulse}, 64'h0);
  endtask

  task automatic tFoldAccrue;
    loadReg(64'h0);
    runOp(2'd0, '0, '0, 2'd0, 5'b00001);
    chk("R4 inexact accrue", statusReg, 64'h21);
    runOp(2'd0, '0, '0, 2'd0, 5'b00100);
    chk("R4 underflow merge", statusReg, 64'hA5);
    chk("R4 no trap", {63'h0, trapPulse}, 64'h0);
  endtask

  task automatic tFoldTrap;
    loadReg(64'h0400_0020);
    runOp(2'd0, '0, '0, 2'd0, 5'b01000);
    chk("R5 trap reg", statusReg, 64'h0400_4028);
    chk("R5 trap pulse", {63'h0, trapPulse}, 64'h1);
    @(negedge clk);
    chk("R13 pulse ends", {63'h0, trapPulse}, 64'h0);
  endtask

  task automatic tCompareBasic;
    loadReg(64'h0);
    runOp(2'd1, ONE, TWO, 2'd0, 5'd0);
    chk("R6 less", statusReg, 64'h400);
    runOp(2'd1, TWO, ONE, 2'd0, 5'd0);
    chk("R6 greater", statusReg, 64'h800);
    runOp(2'd1, ONE, ONE, 2'd0, 5'd0);
    chk("R6 equal", statusReg, 64'h0);
    runOp(2'd1, 32'h8000_0000, 32'h0, 2'd0, 5'd0);
    chk("R7 signed zeros equal", statusReg, 64'h0);
    runOp(2'd1, MTWO, MONE, 2'd0, 5'd0);
    chk("R7 -2 less -1", statusReg, 64'h400);
    runOp(2'd1, MONE, ONE, 2'd0, 5'd0);
    chk("R7 -1 less +1", statusReg, 64'h400);
  endtask

  task automatic tFieldSelect;
    loadReg(64'h0);
    runOp(2'd1, TWO, ONE, 2'd1, 5'd0);
    chk("R6 field 1", statusReg, 64'h2_0000_0000);
    runOp(2'd1, ONE, TWO, 2'd2, 5'd0);
    chk("R6 field 2", statusReg, 64'h6_0000_0000);
    runOp(2'd1, QNAN, ONE, 2'd3, 5'd0);
    chk("R8 quiet qNaN unordered no flag", statusReg, 64'h36_0000_0000);
    runOp(2'd1, TWO, ONE, 2'd0, 5'd0);
    chk("R6 field 0 others kept", statusReg, 64'h36_0000_0800);
  endtask

  task automatic tNanFlags;
    loadReg(64'h0);
    runOp(2'd1, SNAN, ONE, 2'd0, 5'd0);
    chk("R8 quiet sNaN invalid", statusReg, 64'hE10);
    loadReg(64'h0);
    runOp(2'd2, ONE, QNAN, 2'd0, 5'd0);
    chk("R9 signalling qNaN invalid", statusReg, 64'hE10);
    loadReg(64'h0);
    runOp(2'd2, ONE, TWO, 2'd0, 5'd0);
    chk("R9 signalling ordered", statusReg, 64'h400);
  endtask

  task automatic tCompareTrap;
    loadReg(64'h0800_0800);
    runOp(2'd2, QNAN, ONE, 2'd0, 5'd0);
    chk("R10 fcc kept on trap", statusReg, 64'h0800_4810);
    chk("R10 trap pulse", {63'h0, trapPulse}, 64'h1);
    @(negedge clk);
    chk("R13 pulse ends", {63'h0, trapPulse}, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tLoadRound();
    tZeroFoldAndIdle();
    tFoldAccrue();
    tFoldTrap();
    tCompareBasic();
    tFieldSelect();
    tNanFlags();
    tCompareTrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule